// File: doc/BRIEF.md
# Serial Port Host Register Front End

This block is the byte-wide register face of a serial port as a CPU sees it over a small port bus: an address, a read strobe, a write strobe and 8-bit data in each direction. It holds one received byte, one byte waiting to be sent, a line status register and an interrupt enable register. The receive and transmit data registers share one address. A read cycle at that address returns the received byte, and a write cycle at it loads the transmit byte. The block drives one interrupt request line.

The serial shifters are not part of this block. A one-cycle strobe with a byte stands in for the receiver. A valid/take pair stands in for the transmitter, which pulls the pending byte. Software must read the receive register to acknowledge each character, even a character it does not want. That read frees the holding register and drops the receive interrupt.

Read data is combinational from the address whenever the read strobe is high. Every side effect of a read or a write takes place at the clock edge that ends the cycle.

Top module: `uart_host_regs`

## Requirements
- R1: After reset the line status register reads 0x20 (only the transmit-empty flag set), the enable register reads 0x00, `irq` is low and `tx_valid` is low.
- R2: Offset 0 is shared. A read there returns the held received byte, and a write there loads the transmit byte onto `tx_byte`. A write at offset 0 never changes the received byte, and a read at offset 0 never changes `tx_byte`.
- R3: Line status bit 0 (data ready) sets at the edge after a receive strobe and clears at the edge that ends a read of offset 0.
- R4: If a byte arrives while data ready is set and no offset-0 read happens in that cycle, the held byte is kept and line status bit 1 (overrun) sets. Overrun clears at the end of a read of offset 5 (line status), unless a new overrun happens in that same cycle.
- R5: Line status bit 5 (transmit empty) clears at the edge after a write at offset 0, so `tx_valid` rises. It sets again at the edge where `tx_take` is high while a byte is pending.
- R6: Offset 1 is the enable register. Bits 1:0 are stored, and bits 7:2 always read as zero.
- R7: `irq` is high exactly when (enable bit 0 and data ready) or (enable bit 1 and transmit empty). A read of the line status register does not drop a pending receive interrupt. Only an offset-0 read does.
- R8: If a receive strobe and an offset-0 read fall in the same cycle, the read returns the old byte, the new byte is stored, data ready stays set and no overrun is flagged.
- R9: Writes to offset 5 and to unused offsets change no register. Reads of unused offsets return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register offset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while `bus_rd` is high |
| rx_strobe | input | 1 | One-cycle pulse: a received byte is present |
| rx_byte | input | 8 | Received byte, qualified by `rx_strobe` |
| tx_valid | output | 1 | A transmit byte is pending |
| tx_byte | output | 8 | Pending transmit byte |
| tx_take | input | 1 | Transmit side takes the pending byte |
| irq | output | 1 | Interrupt request |

## Verification
Most wrong internal states reach a pin one edge after the event that caused them. A stuck data-ready or transmit-empty flag shows on `irq` as soon as its enable bit is set, and in the next line status read. A lost acknowledge leaves `irq` high after the offset-0 read that should have dropped it. An overrun that replaces the held byte shows only at the next offset-0 read, as the later byte in place of the earlier one. The bench therefore samples `irq` and `tx_valid` one cycle after each bus cycle, and reads back the data and status registers.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] OFS_DATA = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_IEN  = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_LSTS = 3'd5;

    localparam int LS_READY_BIT = 0;
    localparam int LS_OVR_BIT   = 1;
    localparam int LS_TEMPTY_BIT = 5;

    localparam int IEN_RX_BIT = 0;
    localparam int IEN_TX_BIT = 1;
    localparam int IEN_W      = 2;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              ready;
        logic              ovr;
    } rx_state_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              empty;
    } tx_state_t;

    typedef struct packed {
        logic [IEN_W-1:0] ien;
    } irq_state_t;
endpackage

// File: rtl/uart_rx_hold.sv
module uart_rx_hold
    import uart_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_strobe,
    input  logic [DATA_W-1:0] in_byte,
    input  logic              ack_rd,
    input  logic              sts_rd,
    output logic [DATA_W-1:0] held_byte,
    output logic              ready,
    output logic              ovr
);
    rx_state_t st_d, st_q;
    logic      lost;

    always_comb begin
        st_d = st_q;
        lost = in_strobe && st_q.ready && !ack_rd;
        if (in_strobe && !lost) begin
            st_d.data  = in_byte;
            st_d.ready = 1'b1;
        end else if (ack_rd) begin
            st_d.ready = 1'b0;
        end
        st_d.ovr = lost || (st_q.ovr && !sts_rd);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign held_byte = st_q.data;
    assign ready     = st_q.ready;
    assign ovr       = st_q.ovr;

    assert_byte_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && in_strobe && !ack_rd) |=> ($stable(held_byte) && ovr));
    assert_ack_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && !in_strobe) |=> !ready);
    assert_arrival_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_strobe |=> ready);
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold
    import uart_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_byte,
    input  logic              take,
    output logic [DATA_W-1:0] out_byte,
    output logic              pending,
    output logic              empty
);
    tx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.data  = load_byte;
            st_d.empty = 1'b0;
        end else if (take && !st_q.empty) begin
            st_d.empty = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.data  <= '0;
            st_q.empty <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_byte = st_q.data;
    assign empty    = st_q.empty;
    assign pending  = !st_q.empty;

    assert_load_clears_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (pending && out_byte == $past(load_byte)));
    assert_take_sets_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && pending && !load) |=> empty);
    assert_byte_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(out_byte));
endmodule

// File: rtl/uart_irq_ctl.sv
module uart_irq_ctl
    import uart_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ien_wr,
    input  logic [DATA_W-1:0] ien_wdata,
    input  logic              rx_ready,
    input  logic              tx_empty,
    output logic [DATA_W-1:0] ien_view,
    output logic              irq
);
    irq_state_t st_d, st_q;
    logic [IEN_W-1:0] cause;

    always_comb begin
        st_d = st_q;
        if (ien_wr) begin
            st_d.ien = ien_wdata[IEN_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        cause             = '0;
        cause[IEN_RX_BIT] = st_q.ien[IEN_RX_BIT] && rx_ready;
        cause[IEN_TX_BIT] = st_q.ien[IEN_TX_BIT] && tx_empty;
    end

    assign irq      = |cause;
    assign ien_view = {{(DATA_W-IEN_W){1'b0}}, st_q.ien};

    assert_irq_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ien_view != '0));
    assert_ien_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ien_view[DATA_W-1:IEN_W] == '0);
endmodule

// File: rtl/uart_host_regs.sv
module uart_host_regs
    import uart_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rx_strobe,
    input  logic [DATA_W-1:0] rx_byte,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_byte,
    input  logic              tx_take,
    output logic              irq
);
    logic              rd_data, wr_data, rd_lsts, wr_ien;
    logic [DATA_W-1:0] rx_held, ien_view, lsts;
    logic              rx_ready, rx_ovr, tx_empty;

    always_comb begin
        rd_data = bus_rd && (bus_addr == OFS_DATA);
        wr_data = bus_wr && (bus_addr == OFS_DATA);
        rd_lsts = bus_rd && (bus_addr == OFS_LSTS);
        wr_ien  = bus_wr && (bus_addr == OFS_IEN);
    end

    uart_rx_hold u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_strobe (rx_strobe),
        .in_byte   (rx_byte),
        .ack_rd    (rd_data),
        .sts_rd    (rd_lsts),
        .held_byte (rx_held),
        .ready     (rx_ready),
        .ovr       (rx_ovr)
    );

    uart_tx_hold u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (wr_data),
        .load_byte (bus_wdata),
        .take      (tx_take),
        .out_byte  (tx_byte),
        .pending   (tx_valid),
        .empty     (tx_empty)
    );

    uart_irq_ctl u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ien_wr    (wr_ien),
        .ien_wdata (bus_wdata),
        .rx_ready  (rx_ready),
        .tx_empty  (tx_empty),
        .ien_view  (ien_view),
        .irq       (irq)
    );

    always_comb begin
        lsts                = '0;
        lsts[LS_READY_BIT]  = rx_ready;
        lsts[LS_OVR_BIT]    = rx_ovr;
        lsts[LS_TEMPTY_BIT] = tx_empty;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                OFS_DATA: bus_rdata = rx_held;
                OFS_IEN:  bus_rdata = ien_view;
                OFS_LSTS: bus_rdata = lsts;
                default:  bus_rdata = '0;
            endcase
        end
    end

    assert_read_keeps_tx_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr) |=> $stable(tx_byte));
    assert_write_keeps_rx_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !rx_strobe) |=> $stable(rx_held));
    assert_valid_empty_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid != tx_empty);
endmodule

// File: tb/test_uart_host_regs.sv
module test_uart_host_regs;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       rx_strobe = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       tx_valid, tx_take = 1'b0, irq;
    logic [7:0] tx_byte;
    int         n_checks = 0, n_errors = 0;
    logic       finished = 1'b0;

    always #2.5 clk = ~clk;

    uart_host_regs i_uart_host_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_strobe(rx_strobe), .rx_byte(rx_byte), .tx_valid(tx_valid),
        .tx_byte(tx_byte), .tx_take(tx_take), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic push_rx(input logic [7:0] d);
        @(negedge clk);
        rx_strobe = 1'b1; rx_byte = d;
        @(negedge clk);
        rx_strobe = 1'b0;
    endtask

    task automatic pulse_take();
        @(negedge clk);
        tx_take = 1'b1;
        @(negedge clk);
        tx_take = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        bus_read(3'd5, v); check("R1 lsr", v, 8'h20);
        bus_read(3'd1, v); check("R1 ier", v, 8'h00);
        check("R1 irq", {7'd0, irq}, 8'h00);
        check("R1 tx_valid", {7'd0, tx_valid}, 8'h00);
    endtask

    task automatic t_receive();
        logic [7:0] v;
        push_rx(8'hA5);
        bus_read(3'd5, v); check("R3 dr set", v, 8'h21);
        bus_read(3'd0, v); check("R2 rx read", v, 8'hA5);
        bus_read(3'd5, v); check("R3 dr clear", v, 8'h20);
    endtask

    task automatic t_overrun();
        logic [7:0] v;
        push_rx(8'h11);
        push_rx(8'h22);
        bus_read(3'd5, v); check("R4 ovr set", v, 8'h23);
        bus_read(3'd5, v); check("R4 ovr cleared by lsr read", v, 8'h21);
        bus_read(3'd0, v); check("R4 old byte kept", v, 8'h11);
    endtask

    task automatic t_transmit();
        logic [7:0] v;
        bus_write(3'd0, 8'h3C);
        check("R5 tx_valid", {7'd0, tx_valid}, 8'h01);
        check("R2 tx_byte", tx_byte, 8'h3C);
        bus_read(3'd5, v); check("R5 thre clear", v, 8'h00);
        bus_read(3'd0, v); check("R2 write keeps rx", v, 8'h11);
        check("R2 read keeps tx", tx_byte, 8'h3C);
        pulse_take();
        check("R5 tx_valid after take", {7'd0, tx_valid}, 8'h00);
        bus_read(3'd5, v); check("R5 thre set", v, 8'h20);
    endtask

    task automatic t_interrupts();
        logic [7:0] v;
        bus_write(3'd1, 8'hFF);
        bus_read(3'd1, v); check("R6 ier readback", v, 8'h03);
        check("R7 irq on thre", {7'd0, irq}, 8'h01);
        bus_write(3'd1, 8'h01);
        check("R7 irq thre masked", {7'd0, irq}, 8'h00);
        push_rx(8'h5A);
        check("R7 irq on dr", {7'd0, irq}, 8'h01);
        bus_read(3'd5, v);
        check("R7 irq kept after lsr read", {7'd0, irq}, 8'h01);
        bus_read(3'd0, v);
        check("R7 irq dropped by rx read", {7'd0, irq}, 8'h00);
        bus_write(3'd1, 8'h02);
        bus_write(3'd0, 8'h77);
        check("R7 irq low while tx pending", {7'd0, irq}, 8'h00);
        pulse_take();
        check("R7 irq after take", {7'd0, irq}, 8'h01);
        bus_write(3'd1, 8'h00);
    endtask

    task automatic t_same_cycle();
        logic [7:0] v;
        push_rx(8'h40);
        @(negedge clk);
        bus_addr = 3'd0; bus_rd = 1'b1; rx_strobe = 1'b1; rx_byte = 8'h41;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0; rx_strobe = 1'b0;
        check("R8 old byte returned", v, 8'h40);
        bus_read(3'd5, v); check("R8 dr kept no ovr", v, 8'h21);
        bus_read(3'd0, v); check("R8 new byte stored", v, 8'h41);
    endtask

    task automatic t_ignored();
        logic [7:0] v;
        bus_write(3'd5, 8'h00);
        bus_read(3'd5, v); check("R9 lsr write ignored", v, 8'h20);
        bus_write(3'd7, 8'hFF);
        bus_read(3'd7, v); check("R9 unused reads zero", v, 8'h00);
        bus_read(3'd1, v); check("R9 ier unchanged", v, 8'h00);
        check("R9 irq unchanged", {7'd0, irq}, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_receive();
        t_overrun();
        t_transmit();
        t_interrupts();
        t_same_cycle();
        t_ignored();
        finished = 1'b1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (20000) @(posedge clk);
                n_checks++; n_errors++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule